// File: doc/BRIEF.md
# Double-Buffered SPI Transfer Engine

This block is a byte-oriented SPI master run from one 16-bit control word. It owns two transmit buffers and two receive buffers, each 512 bytes deep. A single index bit in the control word decides which buffer of each pair the host bus sees. The transfer engine works on the other buffer of each pair. Software can therefore fill the next outgoing block, or read the previous incoming one, while a transfer is running on the hidden pair. Swapping the pairs takes one register write.

A transfer moves between 1 and 512 bytes. It always starts at offset 0 of the hidden buffers. The serial clock runs in SPI mode 0 and each byte is sent most significant bit first. Two clock-enable strobes come into the block, a fast one and a slow one. Each strobe pulse marks one half period of the serial clock, and a control bit picks which strobe paces the transfer. Four modes decide what goes out on MOSI and what is kept from MISO:

- write: send the buffer, drop the received bits
- read: send all ones, keep every received byte
- exchange: send the buffer and keep every received byte
- wait-and-read: send all ones, and start storing only at the first received byte that is not 0xFF

A running transfer can be cancelled. The cancel takes effect only at the next byte boundary, and the busy flag stays set until then.

Top module: `spi_pp_engine`

## Requirements
- R1: After reset the control read-back is 0x0000, all three chip selects are high (deasserted) and SCLK is low.
- R2: Control bits [8:0] hold the byte count minus one. A transfer that is not aborted produces exactly 8 × (count + 1) rising SCLK edges.
- R3: Mode 0 (bits [10:9] = 0, write) sends hidden TX buffer bytes 0..count in order. It leaves both RX buffers unchanged.
- R4: Mode 1 (read) drives MOSI high for every bit. It stores received byte i at hidden RX offset i, for each byte of the transfer.
- R5: Mode 2 (exchange) sends the hidden TX bytes and at the same time stores every received byte at the same offset of the hidden RX buffer.
- R6: Mode 3 (wait-and-read) drives MOSI high. It stores nothing until the first received byte that differs from 0xFF. That byte goes to RX offset 0 and each later byte of the transfer goes to the next offset. If every byte is 0xFF, the RX buffers stay unchanged.
- R7: Bit 11 selects the pacing strobe: 0 selects fast_tick and 1 selects slow_tick. SCLK changes level only in the cycle after a pulse of the selected strobe. One bit takes two strobe pulses.
- R8: Bits [13:12] select the device. Value 0 asserts no chip select. Values 1, 2 and 3 drive spi_cs_n[0], [1] and [2] low, respectively, for the whole transfer. At most one chip select is low at any time, and none is low while the block is idle.
- R9: Bit 14 names the host-mapped buffer of each pair. The transfer reads TX and writes RX in the other buffer of each pair.
- R10: Reading bit 15 returns the busy state. While busy, a register write changes none of bits [14:0] and does not restart the transfer.
- R11: Writing bit 15 as 0 while busy requests an abort. Busy stays high until the current byte finishes, so the number of SCLK rising edges is a multiple of 8.
- R12: SCLK idles low. MOSI changes only while SCLK is low, and it is sampled by the device on the rising edge, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Half-bit strobe of the fast serial clock |
| slow_tick | input | 1 | Half-bit strobe of the slow serial clock |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read-back, with bit 15 = busy |
| tx_we | input | 1 | Host write into the mapped TX buffer |
| tx_addr | input | 9 | Host TX byte offset |
| tx_wdata | input | 8 | Host TX byte |
| rx_addr | input | 9 | Host RX byte offset |
| rx_rdata | output | 8 | Mapped RX byte, valid one cycle after rx_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The hardest case to reach is an abort that lands in the middle of a byte. It has to arrive while the engine is partway through a byte, and the evidence is only in how many clock edges follow it. The stimulus starts a long read on the fast strobe and issues the cancel a fixed number of cycles later, at a point inside a byte. It then counts the SCLK rising edges and compares the stored prefix with what the device model sent. A second hard case is wait-and-read with a run of leading 0xFF bytes, including a run that fills the whole transfer. The device model produces this by playing back patterns with a chosen number of leading 0xFF bytes.

// File: rtl/spi_pp_pkg.sv
// Package: shared constants and types for the double-buffered SPI engine.
// Assumes the control word layout is fixed: count[8:0], mode[10:9],
// slow[11], dev[13:12], index[14], go/busy[15].
package spi_pp_pkg;

    localparam int LEN_W  = 9;               // byte-count field width
    localparam int DATA_W = 8;               // serial word width
    localparam int N_DEV  = 3;               // number of chip selects
    localparam int CTRL_W = LEN_W + 7;       // full control word width

    typedef enum logic [1:0] {
        XM_WRITE = 2'd0,
        XM_READ  = 2'd1,
        XM_SWAP  = 2'd2,
        XM_HUNT  = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic             idx;
        logic [1:0]       dev;
        logic             slow;
        xfer_mode_e       mode;
        logic [LEN_W-1:0] last;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_LEAD,
        S_LOW,
        S_HIGH,
        S_TAIL
    } seq_state_e;

endpackage

// File: rtl/spi_pp_pingpong.sv
// Module: a pair of equal byte banks with one write port and one
// registered read port. The bank for each port is picked per access.
// Assumes the caller keeps the two ports on opposite banks.
module spi_pp_pingpong #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 2 * (1 << AW);

    logic [DW-1:0] mem [DEPTH];

    // Storage write and one-cycle registered read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_addr}] <= wr_data;
        end
        rd_data <= mem[{rd_bank, rd_addr}];
    end

endmodule

// File: rtl/spi_pp_regs.sv
// Module: control register. Latches all fields only while idle. While
// busy, a write with bit 15 low becomes an abort request.
// Assumes busy comes from the sequencer, registered.
module spi_pp_regs
    import spi_pp_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         busy,
    output ctrl_t        ctrl,
    output logic         start,
    output logic         abort_req,
    output logic [W-1:0] rd_data
);

    // Field storage: writable only while no transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && !busy) begin
            ctrl <= ctrl_t'(wr_data[W-2:0]);
        end
    end

    // Command decode and read-back composition.
    always_comb begin
        start     = wr_en && !busy && wr_data[W-1];
        abort_req = wr_en && busy && !wr_data[W-1];
        rd_data   = {busy, ctrl};
    end

endmodule

// File: rtl/spi_pp_seq.sv
// Module: transfer sequencer. It paces SCLK from the half-bit strobe,
// shifts bytes out MSB first (mode 0), collects incoming bytes, decides
// which bytes are stored, counts the length, and finishes an abort at a
// byte boundary.
// Assumes the TX read port has one cycle of latency. tx_addr is held
// steady for at least one cycle before each load.
module spi_pp_seq
    import spi_pp_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             abort_req,
    input  xfer_mode_e       mode,
    input  logic [LEN_W-1:0] last,
    input  logic [DW-1:0]    tx_byte,
    input  logic             miso,
    output logic             busy,
    output logic             frame,
    output logic             sclk,
    output logic             mosi,
    output logic [LEN_W-1:0] tx_addr,
    output logic             rx_we,
    output logic [LEN_W-1:0] rx_addr,
    output logic [DW-1:0]    rx_data
);

    localparam int               BIT_W    = $clog2(DW);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

    seq_state_e       state;
    logic [BIT_W-1:0] bit_cnt;
    logic [LEN_W-1:0] byte_cnt;
    logic [LEN_W-1:0] rx_ptr;
    logic [DW-1:0]    txsh;
    logic [DW-1:0]    rxsh;
    logic             abort_pend;
    logic             found;
    logic             tail_half;
    logic             ones_tx;
    logic             byte_end;
    logic             keep;
    logic             stop_now;
    logic [DW-1:0]    load_val;

    // Per-cycle decisions: what to send, when a byte ends, whether to keep it.
    always_comb begin
        ones_tx  = (mode == XM_READ) || (mode == XM_HUNT);
        load_val = ones_tx ? '1 : tx_byte;
        byte_end = (state == S_HIGH) && tick && (bit_cnt == LAST_BIT);
        keep     = (mode == XM_READ) || (mode == XM_SWAP) ||
                   ((mode == XM_HUNT) && (found || (rxsh != '1)));
        stop_now = (byte_cnt == last) || abort_pend || abort_req;
        rx_we    = byte_end && keep;
        rx_addr  = rx_ptr;
        rx_data  = rxsh;
        tx_addr  = ((state == S_LOW) || (state == S_HIGH)) ? byte_cnt + 1'b1 : '0;
        busy     = (state != S_IDLE);
        frame    = state inside {S_LEAD, S_LOW, S_HIGH, S_TAIL};
        mosi     = txsh[DW-1];
    end

    // Abort request memory: cleared by a new start, set by a request.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            abort_pend <= 1'b0;
        end else if (abort_req) begin
            abort_pend <= 1'b1;
        end
    end

    // Main state machine: framing, bit timing and byte bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            sclk      <= 1'b0;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            rx_ptr    <= '0;
            txsh      <= '1;
            rxsh      <= '0;
            found     <= 1'b0;
            tail_half <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state    <= S_PREP;
                        byte_cnt <= '0;
                        rx_ptr   <= '0;
                        found    <= 1'b0;
                    end
                end
                S_PREP: begin
                    state <= S_LEAD;
                end
                S_LEAD: begin
                    if (tick) begin
                        if (abort_pend || abort_req) begin
                            state     <= S_TAIL;
                            tail_half <= 1'b0;
                        end else begin
                            txsh    <= load_val;
                            bit_cnt <= '0;
                            state   <= S_LOW;
                        end
                    end
                end
                S_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rxsh  <= {rxsh[DW-2:0], miso};
                        state <= S_HIGH;
                    end
                end
                S_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bit_cnt == LAST_BIT) begin
                            if (rx_we) begin
                                rx_ptr <= rx_ptr + 1'b1;
                            end
                            if ((mode == XM_HUNT) && (rxsh != '1)) begin
                                found <= 1'b1;
                            end
                            if (stop_now) begin
                                state     <= S_TAIL;
                                tail_half <= 1'b0;
                            end else begin
                                byte_cnt <= byte_cnt + 1'b1;
                                txsh     <= load_val;
                                bit_cnt  <= '0;
                                state    <= S_LOW;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            txsh    <= {txsh[DW-2:0], 1'b1};
                            state   <= S_LOW;
                        end
                    end
                end
                S_TAIL: begin
                    if (tick) begin
                        if (tail_half) begin
                            state <= S_IDLE;
                        end
                        tail_half <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_pp_engine.sv
// Module: top of the double-buffered SPI engine. It joins the control
// register, the sequencer and two buffer pairs. The host sees bank
// `idx` of each pair; the transfer uses the other one.
// Assumes idx cannot change while busy, which the register guarantees.
module spi_pp_engine
    import spi_pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              tx_we,
    input  logic [LEN_W-1:0]  tx_addr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic [LEN_W-1:0]  rx_addr,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [N_DEV-1:0]  spi_cs_n
);

    ctrl_t              ctrl;
    logic               start;
    logic               abort_req;
    logic               busy;
    logic               frame;
    logic               tick;
    logic [LEN_W-1:0]   eng_tx_addr;
    logic [DATA_W-1:0]  eng_tx_byte;
    logic               eng_rx_we;
    logic [LEN_W-1:0]   eng_rx_addr;
    logic [DATA_W-1:0]  eng_rx_data;

    // Pacing strobe selection.
    always_comb tick = ctrl.slow ? slow_tick : fast_tick;

    spi_pp_regs #(.W(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_data   (reg_wdata),
        .busy      (busy),
        .ctrl      (ctrl),
        .start     (start),
        .abort_req (abort_req),
        .rd_data   (reg_rdata)
    );

    spi_pp_seq #(.LEN_W(LEN_W), .DW(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (start),
        .abort_req (abort_req),
        .mode      (ctrl.mode),
        .last      (ctrl.last),
        .tx_byte   (eng_tx_byte),
        .miso      (spi_miso),
        .busy      (busy),
        .frame     (frame),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .tx_addr   (eng_tx_addr),
        .rx_we     (eng_rx_we),
        .rx_addr   (eng_rx_addr),
        .rx_data   (eng_rx_data)
    );

    // TX pair: host writes the mapped bank, engine reads the hidden bank.
    spi_pp_pingpong #(.AW(LEN_W), .DW(DATA_W)) u_tx_pair (
        .clk     (clk),
        .wr_en   (tx_we),
        .wr_bank (ctrl.idx),
        .wr_addr (tx_addr),
        .wr_data (tx_wdata),
        .rd_bank (~ctrl.idx),
        .rd_addr (eng_tx_addr),
        .rd_data (eng_tx_byte)
    );

    // RX pair: engine writes the hidden bank, host reads the mapped bank.
    spi_pp_pingpong #(.AW(LEN_W), .DW(DATA_W)) u_rx_pair (
        .clk     (clk),
        .wr_en   (eng_rx_we),
        .wr_bank (~ctrl.idx),
        .wr_addr (eng_rx_addr),
        .wr_data (eng_rx_data),
        .rd_bank (ctrl.idx),
        .rd_addr (rx_addr),
        .rd_data (rx_rdata)
    );

    // One active-low select per device; device code g+1 drives line g.
    for (genvar g = 0; g < N_DEV; g++) begin : g_cs
        always_comb spi_cs_n[g] = !(frame && (ctrl.dev == 2'(g + 1)));
    end

endmodule

// File: rtl/spi_pp_checker.sv
// Module: protocol checker for spi_pp_engine. It only watches the top
// ports and is attached with the bind below.
// Assumes the default control layout (busy at bit 15, slow at bit 11).
module spi_pp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        fast_tick,
    input logic        slow_tick,
    input logic [15:0] reg_rdata,
    input logic        spi_sclk,
    input logic        spi_mosi,
    input logic [2:0]  spi_cs_n
);

    logic       sclk_d;
    logic [2:0] rise_mod;

    // Rising-edge counter modulo 8, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_mod <= '0;
        end else begin
            sclk_d <= spi_sclk;
            if (!reg_rdata[15]) begin
                rise_mod <= '0;
            end else if (spi_sclk && !sclk_d) begin
                rise_mod <= rise_mod + 1'b1;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (reg_rdata == '0 && spi_cs_n == 3'b111 && !spi_sclk));

    p_edge_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk != $past(spi_sclk)) |->
        ($past(reg_rdata[11]) ? $past(slow_tick) : $past(fast_tick)));

    p_one_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1);

    p_select_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n != 3'b111) |-> reg_rdata[15]);

    p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15] && $past(reg_rdata[15])) |-> $stable(reg_rdata[14:0]));

    p_byte_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[15]) |-> (rise_mod == 3'd0));

    p_sclk_only_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> reg_rdata[15]);

    p_mosi_steady_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

endmodule

bind spi_pp_engine spi_pp_checker i_spi_pp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .reg_rdata (reg_rdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/test_spi_pp_engine.sv
`timescale 1ns/1ps
module test_spi_pp_engine;

    localparam int DEPTH = 512;
    localparam int SLOW_DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_we = 1'b0;
    logic [8:0]  tx_addr = '0;
    logic [7:0]  tx_wdata = '0;
    logic [8:0]  rx_addr = '0;
    logic [7:0]  rx_rdata;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;
    logic [2:0]  spi_cs_n;

    always #2.5 clk = ~clk;

    spi_pp_engine i_spi_pp_engine (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
        .rx_addr(rx_addr), .rx_rdata(rx_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Device model and reference state
    logic [7:0] pat [DEPTH];
    logic [7:0] seen [DEPTH];
    logic [7:0] txm [2][DEPTH];
    logic [7:0] rxm [2][DEPTH];
    bit         rxk [2][DEPTH];
    int         sbit = 0;
    int         rises = 0;
    logic [2:0] cs_seen = '0;
    int         busy_cyc = 0;

    assign spi_miso = (sbit < DEPTH * 8) ? pat[sbit / 8][7 - (sbit % 8)] : 1'b1;

    always @(posedge spi_sclk) begin
        if (rises < DEPTH * 8) seen[rises / 8][7 - (rises % 8)] = spi_mosi;
        rises = rises + 1;
    end
    always @(negedge spi_sclk) sbit = sbit + 1;

    always @(negedge clk) begin
        cs_seen = cs_seen | ~spi_cs_n;
        if (reg_rdata[15]) busy_cyc = busy_cyc + 1;
    end

    // Tick generation: fast every cycle, slow every SLOW_DIV cycles
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            fast_tick = 1'b1;
            c = (c + 1) % SLOW_DIV;
            slow_tick = (c == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int last, input int mode, input bit slow,
                                       input int dev, input bit idx, input bit go);
        return {go, idx, 2'(dev), slow, 2'(mode), 9'(last)};
    endfunction

    function automatic int first_live(input int last);
        for (int i = 0; i <= last; i++) if (pat[i] != 8'hFF) return i;
        return -1;
    endfunction

    function automatic logic [2:0] dev_mask(input int dev);
        return (dev == 0) ? 3'b000 : 3'(1 << (dev - 1));
    endfunction

    task automatic ctrl_write(input logic [15:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic tx_put(input int a, input logic [7:0] d);
        @(negedge clk); tx_we = 1'b1; tx_addr = 9'(a); tx_wdata = d;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic rx_get(input int a, output logic [7:0] d);
        @(negedge clk); rx_addr = 9'(a);
        @(negedge clk); d = rx_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (reg_rdata[15]) @(negedge clk);
    endtask

    task automatic slave_reset();
        sbit = 0; rises = 0; cs_seen = '0; busy_cyc = 0;
    endtask

    function automatic void gen_pat(input int last, input int mode, input int lead);
        for (int i = 0; i < DEPTH; i++) pat[i] = 8'($urandom);
        if (mode == 3) begin
            for (int i = 0; i < lead && i <= last; i++) pat[i] = 8'hFF;
            if (lead <= last && pat[lead] == 8'hFF) pat[lead] = 8'h3C;
        end
    endfunction

    // Compare the host view of RX bank b against the reference for 0..lim-1
    task automatic rx_compare(input bit b, input int lim, input string req);
        logic [7:0] d;
        int bad = 0;
        int first_bad = -1;
        ctrl_write(mk(0, 0, 0, 0, b, 0));
        for (int i = 0; i < lim && i < DEPTH; i++) begin
            rx_get(i, d);
            if (rxk[b][i] && d !== rxm[b][i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(bad == 0, req, "RX bank mismatches (count)", bad, 0);
    endtask

    // Complete transfer with engine bank e
    task automatic run(input int last, input int mode, input bit slow, input int dev,
                       input bit e);
        int n = last + 1;
        int bad = 0;
        int f;
        logic [7:0] b;
        string mreq;
        mreq = (mode == 0) ? "R3" : (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
        ctrl_write(mk(last, mode, slow, dev, e, 0));
        for (int i = 0; i < n; i++) begin
            b = 8'($urandom);
            txm[e][i] = b;
            tx_put(i, b);
        end
        slave_reset();
        ctrl_write(mk(last, mode, slow, dev, !e, 1));
        wait_idle();
        chk(rises == 8 * n, "R2", "rising SCLK edges", rises, 8 * n);
        for (int i = 0; i < n; i++) begin
            b = (mode == 0 || mode == 2) ? txm[e][i] : 8'hFF;
            if (seen[i] !== b) bad++;
        end
        chk(bad == 0, mreq, "MOSI byte mismatches", bad, 0);
        chk(cs_seen == dev_mask(dev), "R8", "chip selects seen", cs_seen, dev_mask(dev));
        chk(spi_cs_n == 3'b111 && !spi_sclk, "R12", "idle pins cs/sclk",
            {spi_cs_n, spi_sclk}, 4'b1110);
        if (slow) chk(busy_cyc >= 16 * SLOW_DIV * n, "R7", "slow busy cycles",
                      busy_cyc, 16 * SLOW_DIV * n);
        else      chk(busy_cyc <= 16 * n + 8, "R7", "fast busy cycles", busy_cyc, 16 * n + 8);
        if (mode == 1 || mode == 2) begin
            for (int i = 0; i < n; i++) begin rxm[e][i] = pat[i]; rxk[e][i] = 1'b1; end
        end else if (mode == 3) begin
            f = first_live(last);
            if (f >= 0)
                for (int k = 0; k <= last - f; k++) begin
                    rxm[e][k] = pat[f + k]; rxk[e][k] = 1'b1;
                end
        end
        rx_compare(e, n + 4, {mreq, "/R9"});
    endtask

    initial begin
        int lm;
        int md;
        logic [15:0] held;
        void'($urandom(32'd7321));
        for (int b = 0; b < 2; b++) for (int i = 0; i < DEPTH; i++) rxk[b][i] = 1'b0;
        for (int i = 0; i < DEPTH; i++) pat[i] = 8'hFF;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 16'h0000, "R1", "control read-back", reg_rdata, 0);
        chk(spi_cs_n == 3'b111, "R1", "chip selects", spi_cs_n, 7);
        chk(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);

        // Directed corners
        gen_pat(0, 2, 0);   run(0, 2, 0, 1, 1'b0);            // single byte exchange
        gen_pat(511, 1, 0); run(511, 1, 0, 2, 1'b0);          // maximum length read
        gen_pat(20, 0, 0);  run(20, 0, 0, 3, 1'b0);           // write keeps RX intact
        gen_pat(9, 3, 3);   run(9, 3, 1, 3, 1'b1);            // hunt, slow clock
        gen_pat(6, 3, 0);
        for (int i = 0; i < DEPTH; i++) pat[i] = 8'hFF;
        run(6, 3, 0, 1, 1'b0);                                // hunt, all 0xFF
        gen_pat(4, 2, 0);   run(4, 2, 0, 0, 1'b1);            // no device selected

        // R10: fields frozen while busy
        gen_pat(300, 1, 0);
        slave_reset();
        ctrl_write(mk(300, 1, 0, 2, 1'b1, 1));
        repeat (20) @(negedge clk);
        held = reg_rdata;
        ctrl_write(mk(5, 2, 1, 3, 1'b0, 1));
        chk(reg_rdata[14:0] == held[14:0], "R10", "fields after busy write",
            reg_rdata[14:0], held[14:0]);
        wait_idle();
        chk(rises == 8 * 301, "R10", "edges of undisturbed transfer", rises, 8 * 301);
        chk(cs_seen == 3'b010, "R10", "device kept", cs_seen, 3'b010);
        for (int i = 0; i <= 300; i++) begin rxm[0][i] = pat[i]; rxk[0][i] = 1'b1; end
        rx_compare(1'b0, 310, "R10");

        // R11: abort in the middle of a byte
        gen_pat(200, 1, 0);
        slave_reset();
        ctrl_write(mk(200, 1, 0, 1, 1'b0, 1));
        repeat (37) @(negedge clk);
        ctrl_write(mk(200, 1, 0, 1, 1'b0, 0));
        chk(reg_rdata[15] == 1'b1, "R11", "busy right after abort", reg_rdata[15], 1);
        wait_idle();
        chk(rises % 8 == 0, "R11", "edges modulo 8", rises % 8, 0);
        chk(rises > 0 && rises < 8 * 201, "R11", "edges cut short", rises, 8 * 201);
        for (int i = 0; i < rises / 8; i++) begin rxm[1][i] = pat[i]; rxk[1][i] = 1'b1; end
        rx_compare(1'b1, rises / 8 + 2, "R11");
        chk(spi_cs_n == 3'b111, "R8", "select released after abort", spi_cs_n, 7);

        // R12: first sampled bit is the MSB of TX byte 0
        gen_pat(1, 0, 0);
        run(1, 0, 0, 2, 1'b1);
        chk(seen[0][7] === txm[1][0][7], "R12", "first bit is MSB", seen[0][7], txm[1][0][7]);

        // Random mix
        for (int t = 0; t < 14; t++) begin
            lm = $urandom_range(0, 63);
            md = $urandom_range(0, 3);
            gen_pat(lm, md, $urandom_range(0, 4));
            run(lm, md, (lm < 8) ? 1'($urandom) : 1'b0, $urandom_range(0, 3), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule